// File: doc/BRIEF.md
# Burst-of-Four Split-Port SRAM Sequencer

This block accepts commands for a small SRAM that has a separate read port and a separate write port. Every accepted command moves four data words. On each rising clock edge it samples an active-low read strobe with its address and an active-low write strobe with its address. It decides which of these commands to accept, and then steps each port through a four-beat burst. Each controller clock carries two beats: one on a rising-edge lane and one on a falling-edge lane.

Acceptance depends on the burst already in flight on that port. A strobe on the cycle right after that port accepted a command is ignored. Every burst therefore runs all four beats, and nothing arriving on either port can cut it short or restart it. The two ports run independently of each other. A small internal array holds the data, so the block can be checked end to end.

Top module: `b4q_burst_sram`

## Requirements
- R1: After reset `rd_valid` is low, both read lanes are zero, every word of the array is zero, and no burst is in progress. The first read and the first write after reset are both accepted.
- R2: In a cycle where `rd_n` and `wr_n` are both high, no burst starts and the array contents stay unchanged.
- R3: A low `rd_n` at an edge starts a read burst, unless a read was accepted at the edge just before. In that case the strobe is ignored and produces no data beats.
- R4: A read accepted at edge n raises `rd_valid` after edges n+1 and n+2. Beats 0 and 1 appear on `rd_data_rise`/`rd_data_fall` after edge n+1, and beats 2 and 3 appear after edge n+2. `rd_valid` is low after any edge that delivers no beats.
- R5: Beat k (k = 0..3) of a burst with base address B uses address {B[AW-1:2], (B[1:0]+k) mod 4}. The order is linear and wraps inside the aligned group of four words.
- R6: A low `wr_n` at an edge starts a write burst, unless a write was accepted at the edge just before. `wr_data_rise`/`wr_data_fall` are stored as beats 0/1 at edge n+1 and as beats 2/3 at edge n+2.
- R7: A burst that has started always completes all four beats. A command on either port during the burst neither truncates it nor restarts it.
- R8: A read and a write may be accepted at the same edge. A read accepted at the same edge as a write to the same words returns the old contents. A read accepted one edge after a write returns the new data.
- R9: The command sequence read, idle, read, write, read, write gives each accepted command its own complete four-beat burst.
- R10: Reads accepted at edges n and n+2 keep `rd_valid` high for four consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe |
| rd_addr | input | ADDR_W | Base address for a read burst |
| wr_n | input | 1 | Active-low write strobe |
| wr_addr | input | ADDR_W | Base address for a write burst |
| wr_data_rise | input | DATA_W | Write data lane for even beats (0, 2) |
| wr_data_fall | input | DATA_W | Write data lane for odd beats (1, 3) |
| rd_data_rise | output | DATA_W | Read data lane for even beats (0, 2) |
| rd_data_fall | output | DATA_W | Read data lane for odd beats (1, 3) |
| rd_valid | output | 1 | High while the read lanes carry a beat pair |

## Verification
A corrupted burst state on the read side shows up at `rd_valid` one edge after the faulty command edge. It appears either as a missing second beat pair or as a pair that should not exist. A wrong base register or a wrong beat index shows up as wrong data on the read lanes within two edges of the read being accepted. A write-side fault stays in the array until a later read returns it, so the bench reads back every written area and compares both lanes cycle by cycle against a behavioural model. Stuck acceptance logic is exposed by strobes held low over many edges and by the alternating read/write pattern.

// File: rtl/b4q_pkg.sv
// Shared types and constants for the burst-of-four split-port SRAM.
// Assumes bursts of exactly four beats, moved two beats per controller clock.
package b4q_pkg;

    localparam int BURST_LEN     = 4;
    localparam int BEATS_PER_CLK = 2;
    localparam int IDX_W         = $clog2(BURST_LEN);

    // Per-port burst state: the pair of beats that the next edge moves.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,   // nothing in flight
        SEQ_LOADED = 2'd1,   // command taken last edge, beats 0/1 next
        SEQ_SECOND = 2'd2    // beats 2/3 next
    } seq_state_t;

endpackage

// File: rtl/b4q_port_seq.sv
// One port's command acceptor and burst address generator.
// Accepts a strobe unless this port accepted one at the previous edge.
// Assumes AW >= IDX_W; addresses wrap inside the aligned four-word group.
module b4q_port_seq
    import b4q_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              strobe_n,
    input  logic [AW-1:0]                     cmd_addr,
    output logic                              go,
    output logic                              pair_act,
    output logic [BEATS_PER_CLK-1:0][AW-1:0]  pair_addr
);

    seq_state_t    state_q;
    seq_state_t    state_d;
    logic [AW-1:0] base_q;
    logic          hi_half;

    // Acceptance: a strobe is ignored only right after this port loaded.
    assign go       = ~strobe_n && (state_q != SEQ_LOADED);
    assign pair_act = (state_q != SEQ_IDLE);
    assign hi_half  = (state_q == SEQ_SECOND);

    // Next-state: a burst moves loaded -> second, then idle or a fresh load.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   state_d = go ? SEQ_LOADED : SEQ_IDLE;
            SEQ_LOADED: state_d = SEQ_SECOND;
            SEQ_SECOND: state_d = go ? SEQ_LOADED : SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // State and base-address registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (go) begin
                base_q <= cmd_addr;
            end
        end
    end

    // Per-lane beat address: the low bits count through the group of four.
    for (genvar ln = 0; ln < BEATS_PER_CLK; ln++) begin : g_lane
        logic [IDX_W-1:0] beat_idx;
        logic [IDX_W-1:0] word_sel;
        assign beat_idx = {hi_half, 1'(ln)};
        assign word_sel = base_q[IDX_W-1:0] + beat_idx;
        assign pair_addr[ln] = {base_q[AW-1:IDX_W], word_sel};
    end

endmodule

// File: rtl/b4q_mem.sv
// Storage array with one write and one read port per beat lane.
// Reads are combinational and see the contents from before this edge's writes.
// Lane addresses within one edge are distinct, so the writes never collide.
module b4q_mem
    import b4q_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [BEATS_PER_CLK-1:0][AW-1:0]  wr_addr,
    input  logic [BEATS_PER_CLK-1:0][DW-1:0]  wr_data,
    input  logic [BEATS_PER_CLK-1:0][AW-1:0]  rd_addr,
    output logic [BEATS_PER_CLK-1:0][DW-1:0]  rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    // Array update: cleared on reset, otherwise one word per lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            for (int ln = 0; ln < BEATS_PER_CLK; ln++) begin
                words[wr_addr[ln]] <= wr_data[ln];
            end
        end
    end

    // Combinational read of each lane.
    for (genvar ln = 0; ln < BEATS_PER_CLK; ln++) begin : g_rd
        assign rd_data[ln] = words[rd_addr[ln]];
    end

endmodule

// File: rtl/b4q_burst_sram.sv
// Top level: split read/write ports, each sequenced in bursts of four beats.
// A read accepted at edge n delivers beats after edges n+1 and n+2.
// A write accepted at edge n stores beats at edges n+1 and n+2.
module b4q_burst_sram
    import b4q_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data_rise,
    input  logic [DATA_W-1:0] wr_data_fall,
    output logic [DATA_W-1:0] rd_data_rise,
    output logic [DATA_W-1:0] rd_data_fall,
    output logic              rd_valid
);

    logic                                  rd_go;
    logic                                  rd_pair_act;
    logic [BEATS_PER_CLK-1:0][ADDR_W-1:0]  rd_pair_addr;
    logic                                  wr_go;
    logic                                  wr_pair_act;
    logic [BEATS_PER_CLK-1:0][ADDR_W-1:0]  wr_pair_addr;
    logic [BEATS_PER_CLK-1:0][DATA_W-1:0]  wr_lanes;
    logic [BEATS_PER_CLK-1:0][DATA_W-1:0]  rd_lanes;

    b4q_port_seq #(.AW(ADDR_W)) u_rd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n  (rd_n),
        .cmd_addr  (rd_addr),
        .go        (rd_go),
        .pair_act  (rd_pair_act),
        .pair_addr (rd_pair_addr)
    );

    b4q_port_seq #(.AW(ADDR_W)) u_wr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n  (wr_n),
        .cmd_addr  (wr_addr),
        .go        (wr_go),
        .pair_act  (wr_pair_act),
        .pair_addr (wr_pair_addr)
    );

    // Lane 0 carries the even beats, lane 1 the odd beats.
    assign wr_lanes = {wr_data_fall, wr_data_rise};

    b4q_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_pair_act),
        .wr_addr (wr_pair_addr),
        .wr_data (wr_lanes),
        .rd_addr (rd_pair_addr),
        .rd_data (rd_lanes)
    );

    // Read output register: captures one beat pair per active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_rise <= '0;
            rd_data_fall <= '0;
            rd_valid     <= 1'b0;
        end else begin
            rd_valid <= rd_pair_act;
            if (rd_pair_act) begin
                rd_data_rise <= rd_lanes[0];
                rd_data_fall <= rd_lanes[1];
            end
        end
    end

endmodule

// File: rtl/b4q_burst_sram_chk.sv
// Property checker for b4q_burst_sram, attached via bind below.
// Observes the strobes, the acceptance signals, the burst activity and rd_valid.
module b4q_burst_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_n,
    input logic wr_n,
    input logic rd_go,
    input logic wr_go,
    input logic rd_pair_act,
    input logic wr_pair_act,
    input logic rd_valid
);

    // R1: with no read in flight, a low strobe must be taken.
    p_idle_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pair_act && !rd_n) |-> rd_go);

    // R2: deselect starts nothing on either port.
    p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n) |-> !(rd_go || wr_go));

    // R3: no two reads accepted on adjacent edges.
    p_read_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> !rd_go);

    // R4: an accepted read yields two valid cycles.
    p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> (rd_pair_act ##1 rd_valid ##1 rd_valid));

    // R4: valid output only follows an active read pair.
    p_valid_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_pair_act));

    // R6: no two writes accepted on adjacent edges.
    p_write_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go);

    // R7: a started write burst lasts at least two cycles.
    p_write_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_pair_act) |=> wr_pair_act);

    // R7: read output never shows a single lone beat pair.
    p_read_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid);

endmodule

bind b4q_burst_sram b4q_burst_sram_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .rd_go       (rd_go),
    .wr_go       (wr_go),
    .rd_pair_act (rd_pair_act),
    .wr_pair_act (wr_pair_act),
    .rd_valid    (rd_valid)
);

// File: tb/test_b4q_burst_sram.sv
`timescale 1ns/1ps
// Bench: behavioural queue model of both ports, compared every clock.
module test_b4q_burst_sram;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data_rise = '0;
    logic [DW-1:0] wr_data_fall = '0;
    logic [DW-1:0] rd_data_rise;
    logic [DW-1:0] rd_data_fall;
    logic          rd_valid;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    chk_en = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [DW-1:0] mm [NW];
    int            rq[$];
    int            wq[$];
    bit            rd_prev;
    bit            wr_prev;
    bit            exp_valid;
    logic [DW-1:0] exp_rise;
    logic [DW-1:0] exp_fall;

    b4q_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) i_b4q_burst_sram (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_n         (rd_n),
        .rd_addr      (rd_addr),
        .wr_n         (wr_n),
        .wr_addr      (wr_addr),
        .wr_data_rise (wr_data_rise),
        .wr_data_fall (wr_data_fall),
        .rd_data_rise (rd_data_rise),
        .rd_data_fall (rd_data_fall),
        .rd_valid     (rd_valid)
    );

    always #4 clk = ~clk;

    function automatic int beat_addr(input int base, input int k);
        return (base & ~3) | ((base + k) & 3);
    endfunction

    // Model: read out, then write, then accept new commands, at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mm[i] = '0;
            rq.delete();
            wq.delete();
            rd_prev = 1'b0;
            wr_prev = 1'b0;
            exp_valid = 1'b0;
            exp_rise = '0;
            exp_fall = '0;
        end else begin
            bit racc;
            bit wacc;
            if (rq.size() > 0) begin
                int a0;
                int a1;
                a0 = rq.pop_front();
                a1 = rq.pop_front();
                exp_rise = mm[a0];
                exp_fall = mm[a1];
                exp_valid = 1'b1;
            end else begin
                exp_valid = 1'b0;
            end
            if (wq.size() > 0) begin
                int b0;
                int b1;
                b0 = wq.pop_front();
                b1 = wq.pop_front();
                mm[b0] = wr_data_rise;
                mm[b1] = wr_data_fall;
            end
            racc = !rd_n && !rd_prev;
            wacc = !wr_n && !wr_prev;
            if (racc) for (int k = 0; k < 4; k++) rq.push_back(beat_addr(int'(rd_addr), k));
            if (wacc) for (int k = 0; k < 4; k++) wq.push_back(beat_addr(int'(wr_addr), k));
            rd_prev = racc;
            wr_prev = wacc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of the outputs against the model.
    always @(negedge clk) begin
        if (chk_en) begin
            check(rd_valid === exp_valid, cur_req, "rd_valid",
                  DW'(rd_valid), DW'(exp_valid));
            if (exp_valid) begin
                check(rd_data_rise === exp_rise, cur_req, "rd_data_rise", rd_data_rise, exp_rise);
                check(rd_data_fall === exp_fall, cur_req, "rd_data_fall", rd_data_fall, exp_fall);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            errors++;
            $display("FAIL watchdog expired for %s", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // One cycle of stimulus, driven at the falling edge.
    task automatic cyc(input bit rn, input int ra, input bit wn, input int wa);
        @(negedge clk);
        rd_n = rn;
        rd_addr = AW'(ra);
        wr_n = wn;
        wr_addr = AW'(wa);
        wr_data_rise = DW'($urandom);
        wr_data_fall = DW'($urandom);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 1, 0);
    endtask

    task automatic read_group(input int base);
        cyc(0, base, 1, 0);
        cyc(1, 0, 1, 0);
    endtask

    initial begin
        // R1: reset state
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid === 1'b0, "R1", "rd_valid after reset", DW'(rd_valid), '0);
        check(rd_data_rise === '0, "R1", "rise lane after reset", rd_data_rise, '0);
        check(rd_data_fall === '0, "R1", "fall lane after reset", rd_data_fall, '0);
        chk_en = 1'b1;
        cur_req = "R1";
        cyc(0, 8, 0, 8);          // first read and write both accepted
        idle(4);

        // R6 / R5: writes at aligned and unaligned bases, read back
        cur_req = "R6";
        cyc(1, 0, 0, 5);
        cyc(1, 0, 1, 0);
        cyc(1, 0, 0, 16);
        cyc(1, 0, 1, 0);
        cyc(1, 0, 0, 42);
        idle(3);
        cur_req = "R5";
        read_group(4);
        read_group(7);
        read_group(16);
        read_group(43);
        idle(3);

        // R2: deselect with changing data does not modify the array
        cur_req = "R2";
        for (int i = 0; i < 8; i++) cyc(1, i, 1, i);
        read_group(4);
        read_group(16);
        idle(3);

        // R3 / R10: read strobe held low for many edges
        cur_req = "R3";
        for (int i = 0; i < 7; i++) cyc(0, 4 + i * 12, 1, 0);
        idle(3);
        cur_req = "R10";
        cyc(0, 16, 1, 0);
        cyc(1, 0, 1, 0);
        cyc(0, 42, 1, 0);
        idle(4);

        // R7: write strobe held low, and reads hitting both ports mid-burst
        cur_req = "R7";
        for (int i = 0; i < 6; i++) cyc(i[0], 20 + i, 0, 24 + i * 4);
        idle(3);
        for (int i = 0; i < 6; i++) read_group(24 + i * 4);
        idle(3);

        // R8: same-edge collision and write-then-read
        cur_req = "R8";
        cyc(0, 32, 0, 32);
        cyc(1, 0, 1, 0);
        idle(2);
        cyc(1, 0, 0, 36);
        cyc(0, 37, 1, 0);
        idle(4);

        // R9: read, idle, read, write, read, write
        cur_req = "R9";
        cyc(0, 4, 1, 0);
        cyc(1, 0, 1, 0);
        cyc(0, 16, 1, 0);
        cyc(1, 0, 0, 48);
        cyc(0, 48, 1, 0);
        cyc(1, 0, 0, 52);
        idle(4);
        read_group(52);
        idle(3);

        // R4: long random mix on both ports
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 3) == 0, int'($urandom % NW),
                ($urandom % 3) == 0, int'($urandom % NW));
        end
        idle(5);
        chk_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule